// File: doc/BRIEF.md
# Host Command and Completion Queue Port

This block sits on the device side of a memory-mapped 32-bit register window. A host hands work to the device by writing the bus address of a command descriptor to a request port; the address goes into an inbound FIFO that the local engine drains through a simple valid/pop interface. When the engine finishes a command it pushes a completion word into an outbound FIFO, and the host collects completions by reading a reply port. A read of the reply port while no completion is waiting returns an all-ones word, which the host treats as "nothing there".

Around the two queues the block keeps a small set of registers: an interrupt mask with inverted sense (a cleared bit lets the interrupt through), an interrupt status word whose pending bit follows the reply queue, a level interrupt output, a sticky overflow flag for dropped requests, a host-written doorbell word that the local side can see, a scratchpad that tells the host the device firmware is up, and two read-only words that give the location of the configuration structures. A build parameter moves the mask and pending bit from bit 3 down to bit 2 without changing any offset.

Top module: `cmdq_port`

## Requirements
- R1: A write to byte offset 0x40 places the written word at the tail of the inbound queue; the local side sees the oldest queued word on `req_addr` with `req_valid` high and removes it with `req_pop`, so words leave in the order they were written.
- R2: A write to offset 0x40 while the inbound queue already holds `REQ_DEPTH` words is discarded and sets bit 0 of the overflow register at offset 0x3C; that bit stays set until the host writes a word with bit 0 set to offset 0x3C (a new drop in the same cycle wins over the clear).
- R3: A read of offset 0x44 returns, on `bus_rdata` in the cycle after the read strobe, the oldest completion word and removes it; when the reply queue is empty the read returns 0xFFFFFFFF and removes nothing.
- R4: Completion words pass through the reply queue unchanged, including bit 1, which marks a command that ended in error; `rsp_full` is high while the reply queue holds `RSP_DEPTH` words and a push in that state is discarded.
- R5: The interrupt mask at offset 0x34 holds a single bit at position 3 (position 2 when `IRQ_BIT_LOW` is 1); writing a word with that bit clear unmasks, writing it set masks, other bits of the written word are ignored, and a read returns the mask bit in that position.
- R6: The status word at offset 0x30 has the pending bit at the same position as the mask bit, set exactly while the reply queue is non-empty, and all other bits zero.
- R7: `irq` is high exactly while the pending bit is set and the mask bit is clear.
- R8: The scratchpad at offset 0xB0 reads 0 until `fw_ready` has been seen high in some cycle after reset, and 0xFFFF0000 from the next cycle on.
- R9: Offset 0x20 is a read/write doorbell word whose value also drives `door_val`; offsets 0xB4 and 0xB8 return the parameters `CFG_TBL_OFS` and `CFG_MEM_OFS`.
- R10: A read of any other offset, and a read of the write-only offset 0x40, returns 0; a write to any offset other than 0x20, 0x34, 0x3C and 0x40 changes no state.
- R11: After reset both queues are empty, the mask bit is set, `irq` is low, the overflow flag, doorbell and read data are 0 and the scratchpad reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host register write strobe, one cycle per access |
| bus_rd | input | 1 | Host register read strobe, one cycle per access |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt toward the host |
| req_valid | output | 1 | Inbound queue holds at least one descriptor address |
| req_addr | output | 32 | Oldest descriptor address in the inbound queue |
| req_pop | input | 1 | Local side removes the word on `req_addr` |
| rsp_push | input | 1 | Local side offers a completion word |
| rsp_word | input | 32 | Completion word |
| rsp_full | output | 1 | Reply queue cannot accept a word |
| fw_ready | input | 1 | Local firmware reports it is ready |
| door_val | output | 32 | Current doorbell word |

## Verification
The hardest states to reach from the ports are the queue boundaries: the one extra request that must be thrown away while the inbound queue is full, and the one extra completion offered to a full reply queue, whose loss is only visible as the sentinel arriving one read earlier than it would otherwise. The bench reaches them by filling each queue with a full depth of arithmetically generated words, offering one more, then draining the whole queue and checking every word plus the sentinel. A second instance built with the low mask bit shares all stimulus, so a mask write with bit 3 set must mask one instance and leave the other interrupting. A final sweep reads every word offset, writes junk to every unmapped one and reads them all again against a model of the register state.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [7:0] OFS_DOOR = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_MASK = 8'h34;
  localparam logic [7:0] OFS_OVF  = 8'h3C;
  localparam logic [7:0] OFS_REQ  = 8'h40;
  localparam logic [7:0] OFS_RSP  = 8'h44;
  localparam logic [7:0] OFS_SCR  = 8'hB0;
  localparam logic [7:0] OFS_CTB  = 8'hB4;
  localparam logic [7:0] OFS_CMEM = 8'hB8;

  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] READY_WORD = 32'hFFFF_0000;

  // Position of the shared mask/pending bit for a build variant.
  function automatic int irq_pos(input int low_variant);
    return (low_variant != 0) ? 2 : 3;
  endfunction

  // A 32-bit word with a single bit placed at position pos.
  function automatic logic [31:0] place_bit(input int pos, input logic v);
    logic [31:0] w;
    w = '0;
    w[pos] = v;
    return w;
  endfunction

  // Next pointer value in a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  import cmdq_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign level   = cnt;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= PW'(ring_next(32'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= PW'(ring_next(32'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/cmdq_irq_ctl.sv
module cmdq_irq_ctl #(
  parameter int BITPOS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mask_wr,
  input  logic [31:0] wdata,
  input  logic        pending,
  output logic        mask_q,
  output logic        irq
);

  // Inverted sense: a set bit blocks the interrupt.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (mask_wr) mask_q <= wdata[BITPOS];
  end

  assign irq = pending && !mask_q;

endmodule

// File: rtl/cmdq_rdmux.sv
module cmdq_rdmux #(
  parameter int          AW          = 8,
  parameter int          BITPOS      = 3,
  parameter logic [31:0] CFG_TBL_OFS = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_OFS = 32'h0000_2000
) (
  input  logic [AW-1:0] addr,
  input  logic [31:0]   door,
  input  logic          pending,
  input  logic          mask,
  input  logic          ovf,
  input  logic          ready,
  input  logic          rsp_empty,
  input  logic [31:0]   rsp_head,
  output logic [31:0]   word
);
  import cmdq_pkg::*;

  always_comb begin
    word = '0;
    if      (addr == AW'(OFS_DOOR)) word = door;
    else if (addr == AW'(OFS_STAT)) word = place_bit(BITPOS, pending);
    else if (addr == AW'(OFS_MASK)) word = place_bit(BITPOS, mask);
    else if (addr == AW'(OFS_OVF))  word = place_bit(0, ovf);
    else if (addr == AW'(OFS_RSP))  word = rsp_empty ? EMPTY_WORD : rsp_head;
    else if (addr == AW'(OFS_SCR))  word = ready ? READY_WORD : '0;
    else if (addr == AW'(OFS_CTB))  word = CFG_TBL_OFS;
    else if (addr == AW'(OFS_CMEM)) word = CFG_MEM_OFS;
  end

endmodule

// File: rtl/cmdq_port.sv
module cmdq_port #(
  parameter int          AW          = 8,
  parameter int          REQ_DEPTH   = 16,
  parameter int          RSP_DEPTH   = 16,
  parameter int          IRQ_BIT_LOW = 0,
  parameter logic [31:0] CFG_TBL_OFS = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_OFS = 32'h0000_2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          req_valid,
  output logic [31:0]   req_addr,
  input  logic          req_pop,
  input  logic          rsp_push,
  input  logic [31:0]   rsp_word,
  output logic          rsp_full,
  input  logic          fw_ready,
  output logic [31:0]   door_val
);
  import cmdq_pkg::*;

  localparam int IRQ_POS = irq_pos(IRQ_BIT_LOW);
  localparam int RQ_LW   = $clog2(REQ_DEPTH + 1);
  localparam int RS_LW   = $clog2(RSP_DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic             host_req_wr, host_rsp_rd, mask_wr, ovf_clr, door_wr;
  logic             req_full, req_empty, req_drop;
  logic             rsp_empty;
  logic [RQ_LW-1:0] req_level;
  logic [RS_LW-1:0] rsp_level;
  logic [31:0]      rsp_head, rd_word, rdata_q, door_q;
  logic             mask_q, ovf_q, ready_q, pending;

  assign host_req_wr = bus_wr && (bus_addr == AW'(OFS_REQ));
  assign host_rsp_rd = bus_rd && (bus_addr == AW'(OFS_RSP));
  assign mask_wr     = bus_wr && (bus_addr == AW'(OFS_MASK));
  assign ovf_clr     = bus_wr && (bus_addr == AW'(OFS_OVF)) && bus_wdata[0];
  assign door_wr     = bus_wr && (bus_addr == AW'(OFS_DOOR));
  assign req_drop    = host_req_wr && req_full;
  assign pending     = !rsp_empty;

  cmdq_fifo #(.W(32), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (host_req_wr),
    .pop   (req_pop),
    .din   (bus_wdata),
    .dout  (req_addr),
    .empty (req_empty),
    .full  (req_full),
    .level (req_level)
  );

  cmdq_fifo #(.W(32), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rsp_push),
    .pop   (host_rsp_rd),
    .din   (rsp_word),
    .dout  (rsp_head),
    .empty (rsp_empty),
    .full  (rsp_full),
    .level (rsp_level)
  );

  cmdq_irq_ctl #(.BITPOS(IRQ_POS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (mask_wr),
    .wdata   (bus_wdata),
    .pending (pending),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  cmdq_rdmux #(
    .AW(AW), .BITPOS(IRQ_POS), .CFG_TBL_OFS(CFG_TBL_OFS), .CFG_MEM_OFS(CFG_MEM_OFS)
  ) u_rdmux (
    .addr      (bus_addr),
    .door      (door_q),
    .pending   (pending),
    .mask      (mask_q),
    .ovf       (ovf_q),
    .ready     (ready_q),
    .rsp_empty (rsp_empty),
    .rsp_head  (rsp_head),
    .word      (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      door_q  <= '0;
      ovf_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (bus_rd)        rdata_q <= rd_word;
      if (door_wr)       door_q  <= bus_wdata;
      if (req_drop)      ovf_q   <= 1'b1;
      else if (ovf_clr)  ovf_q   <= 1'b0;
      if (fw_ready)      ready_q <= 1'b1;
    end
  end

  assign bus_rdata = rdata_q;
  assign req_valid = !req_empty;
  assign door_val  = door_q;

endmodule

// File: rtl/cmdq_port_chk.sv
module cmdq_port_chk #(
  parameter int AW        = 8,
  parameter int REQ_DEPTH = 16,
  parameter int RSP_DEPTH = 16,
  localparam int RQ_LW    = $clog2(REQ_DEPTH + 1),
  localparam int RS_LW    = $clog2(RSP_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             rsp_push,
  input logic             rsp_empty,
  input logic             mask_q,
  input logic             req_drop,
  input logic             ovf_q,
  input logic             ready_q,
  input logic [RQ_LW-1:0] req_level,
  input logic [RS_LW-1:0] rsp_level
);
  import cmdq_pkg::*;

  assert_req_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_level <= RQ_LW'(REQ_DEPTH));

  assert_drop_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_drop |=> ovf_q);

  assert_empty_sentinel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(OFS_RSP) && rsp_empty) |=> bus_rdata == EMPTY_WORD);

  assert_empty_no_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(OFS_RSP) && rsp_empty && !rsp_push) |=> rsp_empty);

  assert_rsp_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_level <= RS_LW'(RSP_DEPTH));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);

  assert_irq_has_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rsp_empty);

  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

endmodule

bind cmdq_port cmdq_port_chk #(.AW(AW), .REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .rsp_push  (rsp_push),
  .rsp_empty (rsp_empty),
  .mask_q    (mask_q),
  .req_drop  (req_drop),
  .ovf_q     (ovf_q),
  .ready_q   (ready_q),
  .req_level (req_level),
  .rsp_level (rsp_level)
);

// File: tb/cmdq_port_tb.sv
`timescale 1ns/1ps
module cmdq_port_tb;

  localparam int DEPTH = 16;
  localparam logic [31:0] CTB = 32'h0000_1000;
  localparam logic [31:0] CMEM = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        req_pop = 1'b0, rsp_push = 1'b0, fw_ready = 1'b0;
  logic [31:0] rsp_word = '0;

  logic [31:0] rdata, rdata_a, req_addr, req_addr_a, door, door_a;
  logic        irq, irq_a, req_valid, req_valid_a, rsp_full, rsp_full_a;

  int total = 0;
  int bad = 0;

  // Bench model of register state for the sweep.
  logic [31:0] m_door = '0;
  logic        m_mask = 1'b1;
  logic        m_ready = 1'b0;

  always #2 clk = ~clk;

  cmdq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq), .req_valid(req_valid),
    .req_addr(req_addr), .req_pop(req_pop), .rsp_push(rsp_push), .rsp_word(rsp_word),
    .rsp_full(rsp_full), .fw_ready(fw_ready), .door_val(door)
  );

  cmdq_port #(.IRQ_BIT_LOW(1)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a), .req_valid(req_valid_a),
    .req_addr(req_addr_a), .req_pop(req_pop), .rsp_push(rsp_push), .rsp_word(rsp_word),
    .rsp_full(rsp_full_a), .fw_ready(fw_ready), .door_val(door_a)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] da);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rdata; da = rdata_a;
  endtask

  task automatic lpush(input logic [31:0] w);
    @(negedge clk);
    rsp_push = 1'b1; rsp_word = w;
    @(negedge clk);
    rsp_push = 1'b0;
  endtask

  function automatic logic [31:0] req_val(input int i);
    return 32'h8000_0000 + 32'(i) * 32'h0000_0040;
  endfunction

  function automatic logic [31:0] rsp_val(input int i);
    return (32'(i) << 4) | ((i % 3 == 0) ? 32'h2 : 32'h0);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h20:   return m_door;
      8'h34:   return m_mask ? 32'h8 : 32'h0;
      8'h44:   return 32'hFFFF_FFFF;
      8'hB0:   return m_ready ? 32'hFFFF_0000 : 32'h0;
      8'hB4:   return CTB;
      8'hB8:   return CMEM;
      default: return 32'h0;
    endcase
  endfunction

  task automatic sweep(input string tag);
    logic [31:0] d, da;
    for (int a = 0; a < 256; a += 4) begin
      rd(8'(a), d, da);
      chk($sformatf("%s off=%02h", tag, a), d, exp_rd(8'(a)));
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, da;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11 rdata", rdata, 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 req_valid", 32'(req_valid), 0);
    chk("R11 door", door, 0);
    rd(8'h34, d, da);
    chk("R11 R5 mask reset", d, 32'h8);
    chk("R11 R5 alt mask reset", da, 32'h4);
    rd(8'h30, d, da);
    chk("R11 R6 status", d, 0);
    rd(8'hB0, d, da);
    chk("R11 R8 scratch", d, 0);
    rd(8'h44, d, da);
    chk("R11 R3 empty sentinel", d, 32'hFFFF_FFFF);

    // R1 / R2: fill inbound queue, one extra is dropped
    for (int i = 0; i < DEPTH; i++) wr(8'h40, req_val(i));
    rd(8'h3C, d, da);
    chk("R2 no overflow at depth", d, 0);
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h3C, d, da);
    chk("R2 overflow set", d, 1);
    wr(8'h3C, 32'h0000_0002);
    rd(8'h3C, d, da);
    chk("R2 write without bit0 keeps flag", d, 1);
    rd(8'h40, d, da);
    chk("R10 request port reads 0", d, 0);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk($sformatf("R1 valid %0d", i), 32'(req_valid), 1);
      chk($sformatf("R1 order %0d", i), req_addr, req_val(i));
      req_pop = 1'b1;
      @(negedge clk);
      req_pop = 1'b0;
    end
    chk("R1 R2 drained, extra dropped", 32'(req_valid), 0);
    wr(8'h3C, 32'h1);
    rd(8'h3C, d, da);
    chk("R2 overflow cleared", d, 0);

    // R5 / R6 / R7: interrupt path, both variants
    wr(8'h34, 32'hFFFF_FFF3);  // bits 3 and 2 clear: unmask both variants
    m_mask = 1'b0;
    chk("R7 unmasked empty irq low", 32'(irq), 0);
    lpush(rsp_val(0));
    chk("R7 irq high", 32'(irq), 1);
    chk("R7 alt irq high", 32'(irq_a), 1);
    rd(8'h30, d, da);
    chk("R6 status pending", d, 32'h8);
    chk("R6 alt status pending", da, 32'h4);
    wr(8'h34, 32'h0000_0008);
    chk("R5 bit3 masks", 32'(irq), 0);
    chk("R5 bit3 ignored by low variant", 32'(irq_a), 1);
    rd(8'h34, d, da);
    chk("R5 mask readback", d, 32'h8);
    chk("R5 alt mask readback", da, 32'h0);
    wr(8'h34, 32'h0000_0004);
    chk("R5 bit2 ignored by default variant", 32'(irq), 1);
    chk("R5 bit2 masks low variant", 32'(irq_a), 0);
    wr(8'h34, 32'h0);
    lpush(rsp_val(1));
    lpush(rsp_val(2));
    for (int i = 0; i < 3; i++) begin
      rd(8'h44, d, da);
      chk($sformatf("R3 R4 reply %0d", i), d, rsp_val(i));
    end
    chk("R7 irq drops when empty", 32'(irq), 0);
    rd(8'h30, d, da);
    chk("R6 status clear", d, 0);
    rd(8'h44, d, da);
    chk("R3 sentinel after drain", d, 32'hFFFF_FFFF);

    // R4: fill reply queue, extra discarded
    for (int i = 0; i < DEPTH; i++) lpush(rsp_val(i + 5));
    chk("R4 full", 32'(rsp_full), 1);
    lpush(32'h1234_5678);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h44, d, da);
      chk($sformatf("R4 reply %0d", i), d, rsp_val(i + 5));
    end
    chk("R4 not full", 32'(rsp_full), 0);
    rd(8'h44, d, da);
    chk("R4 R3 extra push discarded", d, 32'hFFFF_FFFF);

    // R8: scratchpad
    @(negedge clk);
    fw_ready = 1'b1;
    @(negedge clk);
    fw_ready = 1'b0;
    m_ready = 1'b1;
    rd(8'hB0, d, da);
    chk("R8 scratch ready", d, 32'hFFFF_0000);

    // R9: doorbell and config words
    wr(8'h20, 32'hA5C3_0F01);
    m_door = 32'hA5C3_0F01;
    chk("R9 door output", door, 32'hA5C3_0F01);
    rd(8'hB4, d, da);
    chk("R9 cfg table", d, CTB);
    rd(8'hB8, d, da);
    chk("R9 cfg mem", d, CMEM);

    // R10: full sweep, junk writes to unmapped offsets, sweep again
    sweep("R10 sweep1");
    for (int a = 0; a < 256; a += 4) begin
      if (a != 8'h20 && a != 8'h34 && a != 8'h3C && a != 8'h40)
        wr(8'(a), 32'hFFFF_FFFF);
    end
    chk("R10 junk writes no irq", 32'(irq), 0);
    chk("R10 junk writes no request", 32'(req_valid), 0);
    sweep("R10 sweep2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule